// File: doc/BRIEF.md
# Serial Channel Command and Mode Register Front End

This block is the register face of one serial channel. A host reaches it over a byte-wide bus with a two-bit address. It keeps the channel's character format and FIFO options in three mode registers that share one address. It turns command-register writes into enable, disable, reset and break actions for separate transmitter and receiver engines. It also gathers ready flags and error events into one status byte.

The three mode registers are called mode 0, mode 1 and mode 2. One address reaches all of them through an internal pointer. Each write to that address stores into the register under the pointer and then moves the pointer on. Command codes in the upper nibble of the command byte move the pointer back. The shift engines, FIFOs and baud generator sit outside the block. They supply level flags and one-cycle event pulses, and they take the decoded format fields, enables and reset strobes.

Top module: `uart_chan_regs`

## Requirements
- R1: After reset, both enables, both reset strobes, break sending and the break-change latch are 0, all three mode registers and the clock-select byte are 0, the status error bits are 0, and the mode pointer selects mode 1.
- R2: Address 0 is the mode register, address 1 reads status and writes the clock-select byte, address 2 is the command register, and address 3 reads received data and writes transmit data. An access at address 3 raises rx_pop_o (on a read) or tx_push_o (on a write) in the same cycle. A read at address 2 returns 0.
- R3: A write to address 0 stores into the register under the pointer and advances the pointer: mode 0 goes to mode 1, mode 1 goes to mode 2, and mode 2 stays on mode 2. Command code 1 (wdata[7:4]) points at mode 1 and code 11 points at mode 0. A read at address 0 returns the pointed register and does not move the pointer.
- R4: Command bits 0, 1, 2 and 3 are receiver enable, receiver disable, transmitter enable and transmitter disable. The new enable state shows the cycle after the write. When an enable bit and a disable bit arrive in the same write, the disable bit wins.
- R5: Command code 2 gives a one-cycle rx_rst_o pulse and code 3 a one-cycle tx_rst_o pulse, both in the cycle after the write. Each also clears its own enable, even when the same write sets the enable bit.
- R6: Status bits 0 to 3 follow the receive-ready, receive-full, transmit-ready and transmitter-empty inputs. Bits 4 to 7 (overrun, parity, framing, received break) are sticky: an event pulse sets them and they stay set. Command code 4 clears them, and it wins over an event that arrives in the same cycle.
- R7: A pulse on brk_chg_i sets brk_chg_o, and command code 5 clears it.
- R8: Command code 6 sets break_send_o and code 7 clears it.
- R9: Mode 1 bits 1:0 drive word_len_o, where 0 to 3 mean 5 to 8 data bits. Mode 1 bits 4:2 set parity: 0 is even (par_en_o=1, par_odd_o=0), 1 is odd (1,1) and 4 is none (par_en_o=0). A mode 2 low nibble of 15 sets stop_two_o; a value of 7 clears it.
- R10: Mode 0 bit 3 drives fifo_ext_o, bit 4 drives tx_lvl_o, and bits 2:0 drive baud_tab_o (0, 1 or 5).
- R11: A write at address 1 loads clk_sel_o from wdata and leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Bus access select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rx_rdy_i | input | 1 | Receive data ready |
| rx_full_i | input | 1 | Receive FIFO full |
| tx_rdy_i | input | 1 | Transmitter can accept data |
| tx_empty_i | input | 1 | Transmitter fully drained |
| ovr_ev_i | input | 1 | Overrun event pulse |
| par_ev_i | input | 1 | Parity error event pulse |
| frm_ev_i | input | 1 | Framing error event pulse |
| brk_ev_i | input | 1 | Received break event pulse |
| brk_chg_i | input | 1 | Break change event pulse |
| rx_data_i | input | 8 | Received character |
| rx_pop_o | output | 1 | Receive holding read strobe |
| tx_push_o | output | 1 | Transmit holding write strobe |
| tx_data_o | output | 8 | Character to transmit |
| clk_sel_o | output | 8 | Clock-select byte |
| rx_en_o | output | 1 | Receiver enabled |
| tx_en_o | output | 1 | Transmitter enabled |
| rx_rst_o | output | 1 | Receiver reset strobe |
| tx_rst_o | output | 1 | Transmitter reset strobe |
| break_send_o | output | 1 | Send break on line |
| brk_chg_o | output | 1 | Break-change latch |
| word_len_o | output | 2 | Data bits code (0..3 = 5..8 bits) |
| par_en_o | output | 1 | Parity generated and checked |
| par_odd_o | output | 1 | Odd parity selected |
| stop_two_o | output | 1 | Two stop bits |
| fifo_ext_o | output | 1 | Extended FIFO enabled |
| tx_lvl_o | output | 1 | Transmit interrupt level select |
| baud_tab_o | output | 3 | Baud table select |

## Verification
The bench walks the mode pointer through every transition, including a run of writes that stays on mode 2. A pointer that wrapped would overwrite mode 0 or mode 1, and a pointer that advanced on reads would return the wrong register. It sends writes that set an enable bit together with a disable bit or a reset code. A design that gave the enable priority would leave the engine running after a disable or a reset. It also fires an error event in the same cycle as the error-reset command. A design that let the event win would keep a stale error bit that only another reset command would clear.

// File: rtl/uart_chan_regs.sv
module uart_chan_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx_rdy_i,
  input  logic       rx_full_i,
  input  logic       tx_rdy_i,
  input  logic       tx_empty_i,
  input  logic       ovr_ev_i,
  input  logic       par_ev_i,
  input  logic       frm_ev_i,
  input  logic       brk_ev_i,
  input  logic       brk_chg_i,
  input  logic [7:0] rx_data_i,
  output logic       rx_pop_o,
  output logic       tx_push_o,
  output logic [7:0] tx_data_o,
  output logic [7:0] clk_sel_o,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       rx_rst_o,
  output logic       tx_rst_o,
  output logic       break_send_o,
  output logic       brk_chg_o,
  output logic [1:0] word_len_o,
  output logic       par_en_o,
  output logic       par_odd_o,
  output logic       stop_two_o,
  output logic       fifo_ext_o,
  output logic       tx_lvl_o,
  output logic [2:0] baud_tab_o
);

  localparam logic [3:0] C_PTR1   = 4'd1;
  localparam logic [3:0] C_RXRST  = 4'd2;
  localparam logic [3:0] C_TXRST  = 4'd3;
  localparam logic [3:0] C_ERRCLR = 4'd4;
  localparam logic [3:0] C_BCHCLR = 4'd5;
  localparam logic [3:0] C_BRKON  = 4'd6;
  localparam logic [3:0] C_BRKOFF = 4'd7;
  localparam logic [3:0] C_PTR0   = 4'd11;

  localparam logic [1:0] P_M0 = 2'd0;
  localparam logic [1:0] P_M1 = 2'd1;
  localparam logic [1:0] P_M2 = 2'd2;

  logic       wr_mode, wr_csr, wr_cmd;
  logic [3:0] cmd;
  logic [1:0] ptr;
  logic [7:0] mr0, mr1, mr2;
  logic [3:0] err;
  logic [7:0] status;

  assign wr_mode = sel & wr & (addr == 2'd0);
  assign wr_csr  = sel & wr & (addr == 2'd1);
  assign wr_cmd  = sel & wr & (addr == 2'd2);
  assign cmd     = wdata[7:4];

  assign tx_push_o = sel & wr & (addr == 2'd3);
  assign rx_pop_o  = sel & rd & (addr == 2'd3);
  assign tx_data_o = wdata;

  assign status = {err, tx_empty_i, tx_rdy_i, rx_full_i, rx_rdy_i};

  always_comb begin
    case (addr)
      2'd0:    rdata = (ptr == P_M0) ? mr0 : (ptr == P_M1) ? mr1 : mr2;
      2'd1:    rdata = status;
      2'd2:    rdata = 8'h00;
      default: rdata = rx_data_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= P_M1;
      mr0 <= 8'h00;
      mr1 <= 8'h00;
      mr2 <= 8'h00;
    end else if (wr_cmd && cmd == C_PTR1) begin
      ptr <= P_M1;
    end else if (wr_cmd && cmd == C_PTR0) begin
      ptr <= P_M0;
    end else if (wr_mode) begin
      case (ptr)
        P_M0:    begin mr0 <= wdata; ptr <= P_M1; end
        P_M1:    begin mr1 <= wdata; ptr <= P_M2; end
        default: mr2 <= wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_sel_o <= 8'h00;
    else if (wr_csr) clk_sel_o <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_o <= 1'b0;
      tx_en_o <= 1'b0;
    end else if (wr_cmd) begin
      if (wdata[1] || cmd == C_RXRST) rx_en_o <= 1'b0;
      else if (wdata[0])              rx_en_o <= 1'b1;
      if (wdata[3] || cmd == C_TXRST) tx_en_o <= 1'b0;
      else if (wdata[2])              tx_en_o <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rst_o     <= 1'b0;
      tx_rst_o     <= 1'b0;
      break_send_o <= 1'b0;
      brk_chg_o    <= 1'b0;
      err          <= 4'h0;
    end else begin
      rx_rst_o <= wr_cmd && cmd == C_RXRST;
      tx_rst_o <= wr_cmd && cmd == C_TXRST;
      if (wr_cmd && cmd == C_BRKON)       break_send_o <= 1'b1;
      else if (wr_cmd && cmd == C_BRKOFF) break_send_o <= 1'b0;
      if (wr_cmd && cmd == C_BCHCLR) brk_chg_o <= 1'b0;
      else if (brk_chg_i)            brk_chg_o <= 1'b1;
      if (wr_cmd && cmd == C_ERRCLR) err <= 4'h0;
      else err <= err | {brk_ev_i, frm_ev_i, par_ev_i, ovr_ev_i};
    end
  end

  assign word_len_o = mr1[1:0];
  assign par_en_o   = ~mr1[4];
  assign par_odd_o  = mr1[2];
  assign stop_two_o = (mr2[3:0] == 4'hF);
  assign fifo_ext_o = mr0[3];
  assign tx_lvl_o   = mr0[4];
  assign baud_tab_o = mr0[2:0];

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr != 2'd3);
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && ptr == P_M2) |=> ptr == P_M2);
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && ptr == P_M0) |=> ptr == P_M1);
  p_rx_dis_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[1]) |=> !rx_en_o);
  p_tx_dis_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[3]) |=> !tx_en_o);
  p_rx_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cmd == C_RXRST) |=> (rx_rst_o && !rx_en_o));
  p_tx_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cmd == C_TXRST) |=> (tx_rst_o && !tx_en_o));
  p_err_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cmd == C_ERRCLR) |=> status[7:4] == 4'h0);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_cmd && cmd == C_ERRCLR)) |=> ((status[7:4] & $past(status[7:4])) == $past(status[7:4])));
  p_brk_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cmd == C_BRKON) |=> break_send_o);

endmodule

// File: tb/uart_chan_regs_tb.sv
module uart_chan_regs_tb;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic rx_rdy_i = 0, rx_full_i = 0, tx_rdy_i = 0, tx_empty_i = 0;
  logic ovr_ev_i = 0, par_ev_i = 0, frm_ev_i = 0, brk_ev_i = 0, brk_chg_i = 0;
  logic [7:0] rx_data_i = 0;
  logic rx_pop_o, tx_push_o, rx_en_o, tx_en_o, rx_rst_o, tx_rst_o;
  logic break_send_o, brk_chg_o, par_en_o, par_odd_o, stop_two_o, fifo_ext_o, tx_lvl_o;
  logic [7:0] tx_data_o, clk_sel_o;
  logic [1:0] word_len_o;
  logic [2:0] baud_tab_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  uart_chan_regs u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FIFO FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #2 d = rdata;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 rx_en", rx_en_o, 0); check("R1 tx_en", tx_en_o, 0);
    check("R1 break", break_send_o, 0); check("R1 brkchg", brk_chg_o, 0);
    check("R1 rst strobes", {rx_rst_o, tx_rst_o}, 0);
    check("R1 clk_sel", clk_sel_o, 0);
    bus_rd(2'd1, d); check("R1 status", d, 0);
    bus_rd(2'd0, d); check("R1 mode", d, 0);
  endtask

  task automatic t_pointer;
    logic [7:0] d;
    bus_wr(2'd0, 8'h13);
    check("R1 first write hits mode1", word_len_o, 3);
    check("R9 no parity", par_en_o, 0);
    check("R10 mode0 untouched", baud_tab_o, 0);
    bus_wr(2'd0, 8'h0F); check("R9 two stop", stop_two_o, 1);
    bus_wr(2'd0, 8'h07); check("R9 one stop", stop_two_o, 0);
    check("R3 hold on mode2", word_len_o, 3);
    bus_rd(2'd0, d); check("R3 read mode2", d, 8'h07);
    bus_rd(2'd0, d); check("R3 read no advance", d, 8'h07);
    bus_wr(2'd2, 8'hB0);
    bus_wr(2'd0, 8'h1D);
    check("R10 fifo ext", fifo_ext_o, 1); check("R10 tx lvl", tx_lvl_o, 1);
    check("R10 baud tab", baud_tab_o, 5);
    bus_wr(2'd0, 8'h05);
    check("R3 mode0->mode1 word", word_len_o, 1);
    check("R9 odd parity", {par_en_o, par_odd_o}, 2'b11);
    bus_rd(2'd0, d); check("R3 ptr on mode2", d, 8'h07);
    bus_wr(2'd2, 8'h10);
    bus_rd(2'd0, d); check("R3 code1 to mode1", d, 8'h05);
    bus_wr(2'd0, 8'h02);
    check("R9 even parity", {par_en_o, par_odd_o}, 2'b10);
    check("R9 word 7", word_len_o, 2);
  endtask

  task automatic t_enables;
    bus_wr(2'd2, 8'h05);
    check("R4 enable both", {rx_en_o, tx_en_o}, 2'b11);
    bus_wr(2'd2, 8'h0A);
    check("R4 disable both", {rx_en_o, tx_en_o}, 2'b00);
    bus_wr(2'd2, 8'h05); bus_wr(2'd2, 8'h03);
    check("R4 rx disable wins", {rx_en_o, tx_en_o}, 2'b01);
    bus_wr(2'd2, 8'h0C);
    check("R4 tx disable wins", tx_en_o, 0);
  endtask

  task automatic t_resets;
    bus_wr(2'd2, 8'h05);
    bus_wr(2'd2, 8'h21);
    check("R5 rx_rst pulse", rx_rst_o, 1);
    check("R5 rx reset clears en", {rx_en_o, tx_en_o}, 2'b01);
    @(negedge clk); check("R5 rx_rst one cycle", rx_rst_o, 0);
    bus_wr(2'd2, 8'h35);
    check("R5 tx_rst pulse", tx_rst_o, 1);
    check("R5 tx reset clears en", {rx_en_o, tx_en_o}, 2'b10);
    @(negedge clk); check("R5 tx_rst one cycle", tx_rst_o, 0);
  endtask

  task automatic t_status;
    logic [7:0] d;
    rx_rdy_i = 1; tx_empty_i = 1;
    bus_rd(2'd1, d); check("R6 live bits", d, 8'h09);
    @(negedge clk); ovr_ev_i = 1; par_ev_i = 1;
    @(negedge clk); ovr_ev_i = 0; par_ev_i = 0;
    bus_rd(2'd1, d); check("R6 sticky errors", d, 8'h39);
    bus_wr(2'd1, 8'hA5);
    check("R11 clk_sel", clk_sel_o, 8'hA5);
    bus_rd(2'd1, d); check("R11 status unchanged", d, 8'h39);
    bus_wr(2'd2, 8'h40);
    bus_rd(2'd1, d); check("R6 error reset", d, 8'h09);
    @(negedge clk); sel = 1; wr = 1; addr = 2'd2; wdata = 8'h40; frm_ev_i = 1; brk_ev_i = 1;
    @(negedge clk); sel = 0; wr = 0; frm_ev_i = 0; brk_ev_i = 0;
    bus_rd(2'd1, d); check("R6 clear beats event", d, 8'h09);
    rx_rdy_i = 0; tx_empty_i = 0; rx_full_i = 1; tx_rdy_i = 1;
    bus_rd(2'd1, d); check("R6 live bits 2", d, 8'h06);
  endtask

  task automatic t_break;
    @(negedge clk); brk_chg_i = 1;
    @(negedge clk); brk_chg_i = 0;
    check("R7 latch set", brk_chg_o, 1);
    bus_wr(2'd2, 8'h50); check("R7 latch clear", brk_chg_o, 0);
    bus_wr(2'd2, 8'h60); check("R8 break on", break_send_o, 1);
    bus_wr(2'd2, 8'h70); check("R8 break off", break_send_o, 0);
  endtask

  task automatic t_offsets;
    logic [7:0] d;
    @(negedge clk); sel = 1; wr = 1; addr = 2'd3; wdata = 8'h3C;
    #2 check("R2 tx push", {tx_push_o, rx_pop_o}, 2'b10);
    check("R2 tx data", tx_data_o, 8'h3C);
    @(negedge clk); sel = 0; wr = 0;
    rx_data_i = 8'h99;
    @(negedge clk); sel = 1; rd = 1; addr = 2'd3;
    #2 check("R2 rx pop", {tx_push_o, rx_pop_o}, 2'b01);
    check("R2 rx data", rdata, 8'h99);
    @(negedge clk); sel = 0; rd = 0;
    bus_rd(2'd2, d); check("R2 cmd reads zero", d, 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_enables();
    t_resets();
    t_status();
    t_break();
    t_offsets();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule